// File: doc/BRIEF.md
# Banked Program Counter Sequencer

This block holds the instruction fetch address of a small microcontroller core and picks, once per instruction cycle, where the next fetch comes from. The candidate sources are a plain increment, a conditional skip, a write to the low byte of the counter, a jump or call target, a return address from the stack, and fixed reset and interrupt vectors. The address space is split into two banks by the top counter bit. A jump or call takes that bit from a bank-select input. A skip never leaves the current bank.

The core's clock phase logic pulses `cyc_en` for one clock in every instruction cycle, and the counter only moves on those clocks. Fetch and execute overlap, so the word fetched during a taken transfer is stale. The block raises `flush` for the following instruction cycle, and the decoder runs that cycle as a dummy. For calls and interrupts the block offers the return address to an external stack with a push strobe. For returns it raises a pop strobe and takes the popped value in the same clock.

Top module: `pcseq_top`

## Requirements
- R1: A synchronous active-high `rst` sets `pc` to 0x0000 and clears `flush` on the next clock edge. While `rst` is high, `push_stb` and `pop_stb` stay low.
- R2: Outside reset, `pc` and `flush` change only on clock edges where `cyc_en` is high. Requests present while `cyc_en` is low have no effect on them.
- R3: With no request pending, an enabled edge loads `pc + 1`, wrapping from 0x3FFF to 0x0000.
- R4: A taken skip keeps bit 13 of `pc` and adds 2 to bits 12..0 modulo 8192. So 0x1FFF goes to 0x0001 and 0x3FFF goes to 0x2001.
- R5: A low-byte write keeps `pc` bits 13..8 and replaces bits 7..0 with `low_data`.
- R6: A jump or call loads `pc` bits 12..0 from `jmp_addr` and bit 13 from `bank_bit`.
- R7: A return loads all 14 bits from `ret_addr`, and `pop_stb` is high during that enabled clock.
- R8: An interrupt loads the vector `(irq_sel + 1) * 4`. This gives 0x004, 0x008, 0x00C, 0x010, 0x014 and 0x018 for `irq_sel` 0 to 5.
- R9: When several requests occur in the same cycle, the one that wins is chosen in this order: reset, interrupt, return, jump/call, low-byte write, skip, increment.
- R10: During the enabled clock of a winning call or interrupt, `push_stb` is high and `push_addr` equals `pc` before the load. `push_stb` and `pop_stb` are never high together.
- R11: After an enabled edge whose winning source is anything other than increment or reset, `flush` is high for exactly that next instruction cycle. After an increment edge, `flush` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_en | input | 1 | One pulse per instruction cycle; counter update enable |
| irq_req | input | 1 | Interrupt entry request |
| irq_sel | input | 3 | Interrupt source index, 0 to 5 |
| ret_req | input | 1 | Return-from-subroutine request |
| ret_addr | input | 14 | Value popped from the stack |
| jmp_req | input | 1 | Jump or call request |
| jmp_is_call | input | 1 | Marks the jump as a call (push return address) |
| jmp_addr | input | 13 | Target field from the instruction word |
| bank_bit | input | 1 | Bank select, becomes bit 13 on jump/call |
| low_wr | input | 1 | Write to the counter's low byte |
| low_data | input | 8 | Byte written to the low byte |
| skip_req | input | 1 | Taken conditional skip |
| pc | output | 14 | Current fetch address |
| flush | output | 1 | Discard the word fetched in this instruction cycle |
| push_stb | output | 1 | Push `push_addr` onto the stack |
| push_addr | output | 14 | Return address to push |
| pop_stb | output | 1 | Stack pop, value taken on `ret_addr` |

## Verification
The bench builds the block with its default parameters: a 14-bit counter, an 8-bit low byte, six interrupt vectors spaced four words apart, and a four-clock instruction cycle. With these sizes, both bank edges (0x1FFF and 0x3FFF) can be reached directly through jumps and returns. This exercises the skip wrap in each bank and the full 14-bit increment wrap. Every vector value and the complete priority chain also fit into a few dozen instruction cycles.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;

    localparam int PC_W_DEF       = 14;
    localparam int LOW_W_DEF      = 8;
    localparam int NUM_VEC_DEF    = 6;
    localparam int VEC_STRIDE_DEF = 4;

    // Winning next-address source, ordered lowest to highest priority
    typedef enum logic [2:0] {
        SRC_SEQ  = 3'd0,
        SRC_SKIP = 3'd1,
        SRC_LOW  = 3'd2,
        SRC_JUMP = 3'd3,
        SRC_RET  = 3'd4,
        SRC_VEC  = 3'd5
    } src_e;

    // Requests seen by the arbiter in one instruction cycle
    typedef struct packed {
        logic vec;
        logic ret;
        logic jump;
        logic low;
        logic skip;
    } req_t;

    function automatic logic is_redirect(src_e s);
        return s != SRC_SEQ;
    endfunction

    function automatic logic pushes(src_e s, logic is_call);
        return (s == SRC_VEC) || ((s == SRC_JUMP) && is_call);
    endfunction

    function automatic int sel_width(int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/pcseq_arb.sv
module pcseq_arb
    import pcseq_pkg::*;
(
    input  req_t req,
    output src_e src
);
    always_comb begin
        if (req.vec)       src = SRC_VEC;
        else if (req.ret)  src = SRC_RET;
        else if (req.jump) src = SRC_JUMP;
        else if (req.low)  src = SRC_LOW;
        else if (req.skip) src = SRC_SKIP;
        else               src = SRC_SEQ;
    end
endmodule

// File: rtl/pcseq_vec_rom.sv
module pcseq_vec_rom #(
    parameter int PC_W       = 14,
    parameter int NUM_VEC    = 6,
    parameter int VEC_STRIDE = 4,
    localparam int SEL_W     = pcseq_pkg::sel_width(NUM_VEC)
) (
    input  logic [SEL_W-1:0] sel,
    output logic [PC_W-1:0]  vec_addr
);
    logic [PC_W-1:0] table_q [NUM_VEC];

    for (genvar g = 0; g < NUM_VEC; g++) begin : g_vec
        assign table_q[g] = PC_W'((g + 1) * VEC_STRIDE);
    end

    always_comb begin
        vec_addr = '0;
        for (int i = 0; i < NUM_VEC; i++) begin
            if (sel == SEL_W'(i)) vec_addr = table_q[i];
        end
    end
endmodule

// File: rtl/pcseq_next.sv
module pcseq_next
    import pcseq_pkg::*;
#(
    parameter int PC_W  = 14,
    parameter int LOW_W = 8
) (
    input  logic [PC_W-1:0]  pc,
    input  src_e             src,
    input  logic [LOW_W-1:0] low_data,
    input  logic [PC_W-2:0]  jmp_addr,
    input  logic             bank_bit,
    input  logic [PC_W-1:0]  ret_addr,
    input  logic [PC_W-1:0]  vec_addr,
    output logic [PC_W-1:0]  nxt
);
    localparam int OFF_W = PC_W - 1;

    logic [PC_W-1:0] seq_addr;
    logic [PC_W-1:0] skip_addr;
    logic [PC_W-1:0] low_addr;
    logic [PC_W-1:0] jump_addr;

    assign seq_addr  = pc + PC_W'(1);
    assign skip_addr = {pc[PC_W-1], pc[OFF_W-1:0] + OFF_W'(2)};
    assign low_addr  = {pc[PC_W-1:LOW_W], low_data};
    assign jump_addr = {bank_bit, jmp_addr};

    always_comb begin
        unique case (src)
            SRC_SKIP: nxt = skip_addr;
            SRC_LOW:  nxt = low_addr;
            SRC_JUMP: nxt = jump_addr;
            SRC_RET:  nxt = ret_addr;
            SRC_VEC:  nxt = vec_addr;
            default:  nxt = seq_addr;
        endcase
    end
endmodule

// File: rtl/pcseq_top.sv
module pcseq_top
    import pcseq_pkg::*;
#(
    parameter int PC_W       = PC_W_DEF,
    parameter int LOW_W      = LOW_W_DEF,
    parameter int NUM_VEC    = NUM_VEC_DEF,
    parameter int VEC_STRIDE = VEC_STRIDE_DEF,
    localparam int SEL_W     = sel_width(NUM_VEC)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cyc_en,
    input  logic             irq_req,
    input  logic [SEL_W-1:0] irq_sel,
    input  logic             ret_req,
    input  logic [PC_W-1:0]  ret_addr,
    input  logic             jmp_req,
    input  logic             jmp_is_call,
    input  logic [PC_W-2:0]  jmp_addr,
    input  logic             bank_bit,
    input  logic             low_wr,
    input  logic [LOW_W-1:0] low_data,
    input  logic             skip_req,
    output logic [PC_W-1:0]  pc,
    output logic             flush,
    output logic             push_stb,
    output logic [PC_W-1:0]  push_addr,
    output logic             pop_stb
);
    req_t            req;
    src_e            src;
    logic [PC_W-1:0] vec_addr;
    logic [PC_W-1:0] nxt;
    logic            step;

    assign req = '{vec: irq_req, ret: ret_req, jump: jmp_req, low: low_wr, skip: skip_req};
    assign step = cyc_en && !rst;

    pcseq_arb u_arb (
        .req (req),
        .src (src)
    );

    pcseq_vec_rom #(
        .PC_W       (PC_W),
        .NUM_VEC    (NUM_VEC),
        .VEC_STRIDE (VEC_STRIDE)
    ) u_vec (
        .sel      (irq_sel),
        .vec_addr (vec_addr)
    );

    pcseq_next #(
        .PC_W  (PC_W),
        .LOW_W (LOW_W)
    ) u_next (
        .pc       (pc),
        .src      (src),
        .low_data (low_data),
        .jmp_addr (jmp_addr),
        .bank_bit (bank_bit),
        .ret_addr (ret_addr),
        .vec_addr (vec_addr),
        .nxt      (nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pc    <= '0;
            flush <= 1'b0;
        end else if (cyc_en) begin
            pc    <= nxt;
            flush <= is_redirect(src);
        end
    end

    assign push_stb  = step && pushes(src, jmp_is_call);
    assign pop_stb   = step && (src == SRC_RET);
    assign push_addr = pc;
endmodule

// File: rtl/pcseq_chk.sv
module pcseq_chk #(
    parameter int PC_W = 14
) (
    input logic            clk,
    input logic            rst,
    input logic            cyc_en,
    input logic            irq_req,
    input logic            ret_req,
    input logic            jmp_req,
    input logic [PC_W-2:0] jmp_addr,
    input logic            bank_bit,
    input logic            low_wr,
    input logic            skip_req,
    input logic [PC_W-1:0] pc,
    input logic            flush,
    input logic            push_stb,
    input logic            pop_stb
);
    logic any_req;
    assign any_req = irq_req || ret_req || jmp_req || low_wr || skip_req;

    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (pc == '0) && !flush);

    a_r1_no_strobe_in_reset: assert property (@(posedge clk)
        rst |-> !push_stb && !pop_stb);

    a_r2_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
        !cyc_en |=> $stable(pc) && $stable(flush));

    a_r3_increment: assert property (@(posedge clk) disable iff (rst)
        (cyc_en && !any_req) |=> (pc == PC_W'($past(pc) + 1'b1)) && !flush);

    a_r4_skip_in_bank: assert property (@(posedge clk) disable iff (rst)
        (cyc_en && skip_req && !irq_req && !ret_req && !jmp_req && !low_wr)
        |=> pc[PC_W-1] == $past(pc[PC_W-1]));

    a_r6_jump_target: assert property (@(posedge clk) disable iff (rst)
        (cyc_en && jmp_req && !irq_req && !ret_req)
        |=> pc == {$past(bank_bit), $past(jmp_addr)});

    a_r10_push_pop_exclusive: assert property (@(posedge clk) disable iff (rst)
        $onehot0({push_stb, pop_stb}));

    a_r11_flush_after_redirect: assert property (@(posedge clk) disable iff (rst)
        (cyc_en && any_req) |=> flush);
endmodule

bind pcseq_top pcseq_chk #(.PC_W(PC_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .cyc_en   (cyc_en),
    .irq_req  (irq_req),
    .ret_req  (ret_req),
    .jmp_req  (jmp_req),
    .jmp_addr (jmp_addr),
    .bank_bit (bank_bit),
    .low_wr   (low_wr),
    .skip_req (skip_req),
    .pc       (pc),
    .flush    (flush),
    .push_stb (push_stb),
    .pop_stb  (pop_stb)
);

// File: tb/test_pcseq_top.sv
module test_pcseq_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cyc_en = 1'b0;
    logic        irq_req = 1'b0;
    logic [2:0]  irq_sel = '0;
    logic        ret_req = 1'b0;
    logic [13:0] ret_addr = '0;
    logic        jmp_req = 1'b0;
    logic        jmp_is_call = 1'b0;
    logic [12:0] jmp_addr = '0;
    logic        bank_bit = 1'b0;
    logic        low_wr = 1'b0;
    logic [7:0]  low_data = '0;
    logic        skip_req = 1'b0;
    logic [13:0] pc;
    logic        flush;
    logic        push_stb;
    logic [13:0] push_addr;
    logic        pop_stb;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    int exp_pc = 0;
    int exp_flush = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pcseq_top i_pcseq_top (
        .clk(clk), .rst(rst), .cyc_en(cyc_en),
        .irq_req(irq_req), .irq_sel(irq_sel),
        .ret_req(ret_req), .ret_addr(ret_addr),
        .jmp_req(jmp_req), .jmp_is_call(jmp_is_call), .jmp_addr(jmp_addr),
        .bank_bit(bank_bit), .low_wr(low_wr), .low_data(low_data),
        .skip_req(skip_req), .pc(pc), .flush(flush),
        .push_stb(push_stb), .push_addr(push_addr), .pop_stb(pop_stb)
    );

    task automatic chk(string tag, int act, int exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    // One clock: strobes checked before the edge, state after it (at negedge)
    task automatic clk_cycle(input logic en, input string tag);
        int e_push, e_pop, nxt;
        cyc_en = en;
        #1;
        e_push = (en && !rst && (irq_req || (!ret_req && jmp_req && jmp_is_call))) ? 1 : 0;
        e_pop  = (en && !rst && !irq_req && ret_req) ? 1 : 0;
        chk(rst ? "R1" : "R10", int'(push_stb), e_push);
        chk(rst ? "R1" : "R7",  int'(pop_stb),  e_pop);
        if (e_push == 1) chk("R10", int'(push_addr), exp_pc);
        if (rst) begin
            exp_pc = 0; exp_flush = 0;
        end else if (en) begin
            exp_flush = 1;
            if (irq_req)      nxt = (int'(irq_sel) + 1) * 4;
            else if (ret_req) nxt = int'(ret_addr);
            else if (jmp_req) nxt = (int'(bank_bit) * 8192) + int'(jmp_addr);
            else if (low_wr)  nxt = (exp_pc / 256) * 256 + int'(low_data);
            else if (skip_req) nxt = (exp_pc / 8192) * 8192 + ((exp_pc % 8192) + 2) % 8192;
            else begin
                nxt = (exp_pc + 1) % 16384;
                exp_flush = 0;
            end
            exp_pc = nxt;
        end
        @(posedge clk);
        @(negedge clk);
        chk(en ? tag : "R2", int'(pc), exp_pc);
        chk(en ? "R11" : "R2", int'(flush), exp_flush);
    endtask

    // One instruction cycle: three idle clocks with requests held, then the enabled clock
    task automatic icycle(input string tag);
        for (int k = 0; k < 3; k++) clk_cycle(1'b0, tag);
        clk_cycle(1'b1, tag);
        irq_req = 0; ret_req = 0; jmp_req = 0; jmp_is_call = 0;
        low_wr = 0; skip_req = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end

    initial begin
        @(negedge clk);
        // R1: reset, with requests present that must be ignored
        irq_req = 1; jmp_req = 1; jmp_is_call = 1;
        clk_cycle(1'b1, "R1");
        clk_cycle(1'b0, "R1");
        irq_req = 0; jmp_req = 0; jmp_is_call = 0;
        rst = 0;

        // R3: plain increments
        for (int i = 0; i < 3; i++) icycle("R3");

        // R4: skip inside bank 0 and at the bank 0 top
        skip_req = 1; icycle("R4");
        jmp_req = 1; jmp_addr = 13'h1FFF; bank_bit = 0; icycle("R6");
        skip_req = 1; icycle("R4");
        icycle("R3");

        // R6: jump into bank 1, R4: skip wrap at the bank 1 top
        jmp_req = 1; jmp_addr = 13'h1FFF; bank_bit = 1; icycle("R6");
        skip_req = 1; icycle("R4");
        jmp_req = 1; jmp_addr = 13'h1FFE; bank_bit = 1; icycle("R6");
        skip_req = 1; icycle("R4");

        // R5: low byte write keeps upper bits
        jmp_req = 1; jmp_addr = 13'h1A55; bank_bit = 1; icycle("R6");
        low_wr = 1; low_data = 8'hC3; icycle("R5");
        low_wr = 1; low_data = 8'h00; icycle("R5");

        // R10: call pushes the pre-load counter
        jmp_req = 1; jmp_is_call = 1; jmp_addr = 13'h0123; bank_bit = 0; icycle("R6");
        icycle("R3");

        // R7: return, then R3 full wrap from 0x3FFF
        ret_req = 1; ret_addr = 14'h3FFF; icycle("R7");
        icycle("R3");
        icycle("R3");

        // R8: every interrupt vector
        for (int v = 0; v < 6; v++) begin
            irq_req = 1; irq_sel = 3'(v); icycle("R8");
            icycle("R3");
        end

        // R9: priority chain, removing the winner each time
        irq_req = 1; irq_sel = 3'd2; ret_req = 1; ret_addr = 14'h2222;
        jmp_req = 1; jmp_is_call = 1; jmp_addr = 13'h0444; low_wr = 1; low_data = 8'h77;
        skip_req = 1; icycle("R9");
        ret_req = 1; jmp_req = 1; jmp_is_call = 1; low_wr = 1; skip_req = 1; icycle("R9");
        jmp_req = 1; low_wr = 1; skip_req = 1; icycle("R9");
        low_wr = 1; skip_req = 1; icycle("R9");
        skip_req = 1; icycle("R9");
        icycle("R11");

        // R1: reset mid-run
        rst = 1; clk_cycle(1'b1, "R1");
        rst = 0; icycle("R3");

        done = 1;
        summary();
    end
endmodule